// File: doc/BRIEF.md
# Handshaked Byte Stream Port

This block carries compressed code-stream bytes between an internal byte FIFO and an external host over one synchronous 8-bit bus. The host sees two handshake wires. The block drives a valid line to show it can supply or take a byte. The host drives a hold line when it cannot. A byte crosses the bus only on a rising clock edge where valid is active and hold is not. The active level of each wire is set by its own configuration bit.

A mode input sets the direction of the bus. In encode, one registered output stage feeds the bus from the FIFO read channel. A byte stays on the bus until the host takes it, and the stage refills on the same edge it drains. In decode, bus bytes go straight into the FIFO write channel, and valid follows the FIFO's free-space signal.

In encode, the block also drives an end-of-field marker. The FIFO tags the first byte of the final 32-bit word of a field. The marker then stays high for that byte and the three bytes after it on the bus. The marker has an enable input, which is normally tied high.

Top module: `bstream_port`

## Requirements
- R1: During reset and right after it, the output stage is empty. bus_out is 0, eof_mark is 0 and valid is at its inactive level. In encode, src_ready is 1.
- R2: valid_pin is high when valid is active and valid_pol is 1. It is low when valid is active and valid_pol is 0.
- R3: hold is active when hold_pin equals hold_pol. A hold_pin level different from hold_pol means hold is inactive.
- R4: In encode, a byte is taken from the bus only on a rising edge where valid is active and hold is inactive. Bytes leave in the order the FIFO supplied them, with none lost and none repeated. The stage can drain and refill on the same edge, so back-to-back bytes transfer one per cycle.
- R5: In encode, while hold is active and valid is active, bus_out, eof_mark and valid stay unchanged into the next cycle.
- R6: In encode, valid is inactive whenever no byte is staged, for example after the FIFO runs empty.
- R7: In decode, valid is active exactly when snk_ready is 1. snk_valid is 1 exactly when snk_ready is 1 and hold is inactive, and snk_data equals bus_in.
- R8: bus_oe equals enc_mode. In decode, src_ready is 0, so the FIFO read side is never consumed.
- R9: A 4-byte word counter starts at 0 after reset and advances on every byte loaded into the stage. If src_lastw is 1 on a byte loaded at word position 0, eof_mark is 1 on that byte and on the next three bytes presented on the bus, including while they are held.
- R10: src_lastw on a byte loaded at word position 1, 2 or 3 is ignored, and that byte carries eof_mark 0.
- R11: With mark_en at 0, eof_mark stays 0.
- R12: In decode, eof_mark stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and FIFO clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_mode | input | 1 | 1 = encode (bus driven out), 0 = decode (bus sampled in) |
| valid_pol | input | 1 | Active level of valid_pin |
| hold_pol | input | 1 | Active level of hold_pin |
| mark_en | input | 1 | Enables the end-of-field marker |
| bus_in | input | 8 | Byte sampled from the host in decode |
| bus_out | output | 8 | Byte presented to the host in encode |
| bus_oe | output | 1 | Output enable for the bus pads |
| valid_pin | output | 1 | Valid handshake wire to the host |
| hold_pin | input | 1 | Hold handshake wire from the host |
| eof_mark | output | 1 | End-of-field marker, active high |
| src_data | input | 8 | FIFO read data (encode) |
| src_lastw | input | 1 | FIFO tag: first byte of a field's final word |
| src_valid | input | 1 | FIFO holds a byte to read |
| src_ready | output | 1 | Block takes the FIFO byte this edge |
| snk_data | output | 8 | FIFO write data (decode) |
| snk_valid | output | 1 | FIFO write strobe (decode) |
| snk_ready | input | 1 | FIFO has room (not full) |

## Verification
The case that needs the most care is an edge where the host takes the staged byte and the FIFO loads the next one into the same register. A wrong refill condition shows up there as a lost or repeated byte. The bench provokes this with a gap-free source while hold toggles at several different rates, including rates that line up with FIFO gaps. It compares every byte taken against the supplied sequence, in order. A second coincidence is the start of the marker on a byte that then sits under hold. Here the bench checks that the marker and the data stay frozen together, and that the marker spans exactly four transferred bytes.

// File: rtl/bsp_pkg.sv
// Package bsp_pkg
// Shared constants and helpers for the byte stream port.
// Assumes: handshake wires carry a level, and the polarity bit gives the
// level that means "active".
package bsp_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;

    // Converts between an active flag and a pin level. The mapping is its
    // own inverse, so the same function serves inputs and outputs.
    function automatic logic pol_map(input logic lvl, input logic act_high);
        return act_high ? lvl : ~lvl;
    endfunction
endpackage

// File: rtl/bsp_eof_tracker.sv
// Module bsp_eof_tracker
// Tracks each loaded byte's position inside a word. It decides which
// loaded bytes belong to a field's final word.
// Assumes: load pulses once per byte entering the output stage. tag is
// honoured only at word position 0.
module bsp_eof_tracker #(
    parameter int WORD_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tag,
    output logic mark_now
);
    localparam int LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] left_q;
    logic              start;

    // A marked word starts only on an aligned tagged byte.
    always_comb begin
        start    = tag && (lane_q == '0);
        mark_now = start || (left_q != '0);
    end

    // Advance the word position and count down the marked bytes still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            left_q <= '0;
        end else if (load) begin
            lane_q <= (lane_q == LAST_LANE) ? '0 : lane_q + 1'b1;
            if (start)
                left_q <= LAST_LANE;
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/bsp_enc_stage.sv
// Module bsp_enc_stage
// One-entry output register for encode. It holds a byte and its marker
// until the host takes it, and refills on the same edge it drains.
// Assumes: take is only raised while full is 1.
module bsp_enc_stage #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              take,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_mark,
    output logic              src_ready,
    output logic              load,
    output logic              full,
    output logic [BYTE_W-1:0] data_q,
    output logic              mark_q
);
    // Room exists when the stage is empty or is being emptied this edge.
    always_comb begin
        src_ready = enable && (!full || take);
        load      = src_ready && src_valid;
    end

    // Capture a new byte, or drop to empty after a take with no refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            data_q <= '0;
            mark_q <= 1'b0;
        end else if (load) begin
            full   <= 1'b1;
            data_q <= src_data;
            mark_q <= src_mark;
        end else if (take) begin
            full   <= 1'b0;
        end
    end
endmodule

// File: rtl/bstream_port.sv
// Module bstream_port
// Synchronous byte stream port with a valid/hold handshake. Encode drives
// FIFO bytes out through a register stage. Decode writes bus bytes into the
// FIFO. An end-of-field marker covers the final word of each field.
// Assumes: enc_mode and the polarity bits change only while idle or in reset.
module bstream_port #(
    parameter int BYTE_W     = bsp_pkg::BYTE_W,
    parameter int WORD_BYTES = bsp_pkg::WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_mode,
    input  logic              valid_pol,
    input  logic              hold_pol,
    input  logic              mark_en,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              valid_pin,
    input  logic              hold_pin,
    output logic              eof_mark,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_lastw,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [BYTE_W-1:0] snk_data,
    output logic              snk_valid,
    input  logic              snk_ready
);
    import bsp_pkg::pol_map;

    logic              hold_act;
    logic              valid_act;
    logic              take;
    logic              st_load;
    logic              st_full;
    logic              st_mark;
    logic              mark_now;
    logic [BYTE_W-1:0] st_data;

    // Decode the host's hold level and form the handshake for either direction.
    always_comb begin
        hold_act  = pol_map(hold_pin, hold_pol);
        valid_act = enc_mode ? st_full : snk_ready;
        take      = enc_mode && st_full && !hold_act;
        valid_pin = pol_map(valid_act, valid_pol);
    end

    bsp_eof_tracker #(
        .WORD_BYTES (WORD_BYTES)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_load),
        .tag      (src_lastw),
        .mark_now (mark_now)
    );

    bsp_enc_stage #(
        .BYTE_W (BYTE_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enc_mode),
        .take      (take),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_mark  (mark_now),
        .src_ready (src_ready),
        .load      (st_load),
        .full      (st_full),
        .data_q    (st_data),
        .mark_q    (st_mark)
    );

    // Drive the bus, the marker and the decode-side FIFO write.
    always_comb begin
        bus_out   = st_data;
        bus_oe    = enc_mode;
        eof_mark  = enc_mode && mark_en && st_full && st_mark;
        snk_data  = bus_in;
        snk_valid = !enc_mode && snk_ready && !hold_act;
    end
endmodule

// File: rtl/bsp_chk.sv
// Module bsp_chk
// Handshake and marker properties, seen from the top module's ports.
// Assumes: the polarity bits are steady outside reset.
module bsp_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_mode,
    input logic              valid_pol,
    input logic              hold_pol,
    input logic              mark_en,
    input logic              valid_pin,
    input logic              hold_pin,
    input logic [BYTE_W-1:0] bus_out,
    input logic              eof_mark,
    input logic              src_ready,
    input logic              snk_valid,
    input logic              snk_ready
);
    logic vact;
    logic hact;

    // Recover the active flags from the pin levels.
    always_comb begin
        vact = (valid_pin == valid_pol);
        hact = (hold_pin == hold_pol);
    end

    AST_ENC_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_mode && vact && hact) |=> (!enc_mode || (vact && $stable(bus_out) && $stable(eof_mark)))); // R5
    AST_ENC_NO_TAKE_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_mode && vact && hact) |-> !src_ready); // R4
    AST_DEC_VALID_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_mode |-> (vact == snk_ready)); // R7
    AST_DEC_WRITE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid |-> (!enc_mode && vact && !hact)); // R7
    AST_DEC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_mode |-> !src_ready); // R8
    AST_MARK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc_mode || !mark_en) |-> !eof_mark); // R11
    AST_MARK_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        eof_mark |-> vact); // R9
endmodule

bind bstream_port bsp_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_mode  (enc_mode),
    .valid_pol (valid_pol),
    .hold_pol  (hold_pol),
    .mark_en   (mark_en),
    .valid_pin (valid_pin),
    .hold_pin  (hold_pin),
    .bus_out   (bus_out),
    .eof_mark  (eof_mark),
    .src_ready (src_ready),
    .snk_valid (snk_valid),
    .snk_ready (snk_ready)
);

// File: tb/sim_bstream_port.sv
// Directed bench for bstream_port: one task per scenario, each checking itself.
module sim_bstream_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_mode = 1'b1;
    logic       valid_pol = 1'b1;
    logic       hold_pol = 1'b1;
    logic       mark_en = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       valid_pin;
    logic       hold_pin = 1'b0;
    logic       eof_mark;
    logic [7:0] src_data = '0;
    logic       src_lastw = 1'b0;
    logic       src_valid = 1'b0;
    logic       src_ready;
    logic [7:0] snk_data;
    logic       snk_valid;
    logic       snk_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bstream_port u0 (.*);

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 5);
    endfunction

    task automatic apply_reset(input bit em, input bit vp, input bit hp, input bit me);
        @(negedge clk);
        rst_n = 1'b0;
        enc_mode = em; valid_pol = vp; hold_pol = hp; mark_en = me;
        hold_pin = !hp; src_valid = 0; src_lastw = 0; snk_ready = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: state straight after reset in encode.
    task automatic t_reset();
        apply_reset(1, 1, 1, 1);
        #1;
        chk(valid_pin == 1'b0, "R1 valid idle", valid_pin, 0);
        chk(eof_mark == 1'b0, "R1 marker idle", eof_mark, 0);
        chk(bus_out == 8'h00, "R1 bus_out", bus_out, 0);
        chk(src_ready == 1'b1, "R1 src_ready", src_ready, 1);
        chk(bus_oe == 1'b1, "R8 bus_oe encode", bus_oe, 1);
    endtask

    // R2 R3 R4 R5 R6 R9 R10 R11: stream 16 bytes under a hold and gap pattern.
    task automatic t_encode(input bit vp, input bit hp, input bit me, input int hmod, input int gmod);
        int tx = 0;
        int rx = 0;
        int k = 0;
        bit pstall = 0;
        logic [7:0] pbus = '0;
        logic pmark = 0;
        bit hact;
        bit vact;
        bit expm;
        apply_reset(1, vp, hp, me);
        while (rx < 16) begin
            @(negedge clk);
            k++;
            hact = (hmod != 0) && (k % hmod == 0);
            hold_pin = hp ? hact : !hact;
            if (tx < 16 && !(gmod != 0 && k % gmod == 0)) begin
                src_valid = 1; src_data = pat(tx); src_lastw = (tx == 4 || tx == 13);
            end else begin
                src_valid = 0; src_lastw = 0;
            end
            #1;
            vact = (valid_pin == vp);
            if (pstall)
                chk(vact && bus_out == pbus && eof_mark == pmark, "R5 stall stable", bus_out, pbus);
            if (vact && !hact) begin
                chk(bus_out == pat(rx), "R4 byte order", bus_out, pat(rx));
                expm = me && rx >= 4 && rx <= 7;
                if (!me)
                    chk(eof_mark == 1'b0, "R11 marker off", eof_mark, 0);
                else if (rx >= 12)
                    chk(eof_mark == expm, "R10 unaligned tag", eof_mark, expm);
                else
                    chk(eof_mark == expm, "R9 marker span", eof_mark, expm);
                rx++;
            end
            pstall = vact && hact;
            pbus = bus_out;
            pmark = eof_mark;
            if (src_valid && src_ready) tx++;
        end
        @(negedge clk);
        src_valid = 0; src_lastw = 0; hold_pin = !hp;
        #1;
        chk(valid_pin == !vp, "R6 R2 valid inactive level when empty", valid_pin, !vp);
        chk(tx == 16, "R4 all bytes read", tx, 16);
    endtask

    // R3 R7 R8 R12: decode path with room and hold patterns.
    task automatic t_decode(input bit vp, input bit hp);
        bit hact;
        apply_reset(0, vp, hp, 1);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            snk_ready = (k % 4 != 2);
            hact = (k % 3 == 0);
            hold_pin = hp ? hact : !hact;
            bus_in = 8'(k * 11 + 1);
            src_valid = 1; src_data = 8'hEE; src_lastw = 1;
            #1;
            chk((valid_pin == vp) == snk_ready, "R7 valid follows room", valid_pin, snk_ready);
            chk(snk_valid == (snk_ready && !hact), "R7 R3 write strobe", snk_valid, snk_ready && !hact);
            if (snk_valid) chk(snk_data == bus_in, "R7 write data", snk_data, bus_in);
            chk(!src_ready && !bus_oe, "R8 decode direction", src_ready, 0);
            chk(eof_mark == 1'b0, "R12 no marker in decode", eof_mark, 0);
        end
        src_valid = 0; src_lastw = 0;
    endtask

    initial begin
        t_reset();
        t_encode(1, 1, 1, 0, 0);
        t_encode(1, 1, 1, 3, 5);
        t_encode(0, 0, 1, 2, 0);
        t_encode(1, 0, 0, 4, 3);
        t_encode(0, 1, 1, 2, 2);
        t_decode(1, 1);
        t_decode(0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule